// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 64-bit virtual address into a 48-bit physical address by following a radix tree of four page-table levels held in memory. Every table occupies one 4 KiB page and holds 512 entries of 8 bytes each. The walk starts at the top-level table, whose physical base comes from a privileged root register input. At each level the walker reads one entry and either descends into the next table or finishes the walk.

The walk stops as soon as an entry is missing, and no further reads are issued for that request. The access permissions are collected across all four entries and checked against the access type of the request. The access types are read, write, user mode and instruction fetch.

A requester hands over one translation at a time through a valid/ready handshake. The walker issues its entry reads one at a time through a simple request/response memory port. It returns either the physical address or a fault. A fault names the level at which the walk stopped and says whether the cause was a missing entry or a protection violation. The response stays posted until the requester accepts it.

Top module: `ptw_walker`

## Requirements
- R1: After reset `req_ready_o` is 1, `rsp_valid_o` is 0 and `mem_req_valid_o` is 0.
- R2: The index for the top level is VA[47:39]. The first entry read goes to the root base with bits 11:0 forced to zero, plus 8 times that index. Each later read goes to entry bits 47:12 of the previous entry followed by twelve zero bits, plus 8 times the index for that level. The indices for the lower levels are VA[38:30], VA[29:21] and VA[20:12].
- R3: A walk that succeeds makes exactly four reads and returns `rsp_cause_o` = 0 and `rsp_level_o` = 0. The returned physical address is the final entry's bits 47:12 joined with VA[11:0]. VA[63:48] and entry bits 62:48 have no effect on the result.
- R4: An entry whose bit 0 (present) is 0 ends the walk with `rsp_cause_o` = 1. `rsp_level_o` gives the level where the walk stopped: 3 for the top table, 2, 1, and 0 for the last table. No further read is issued, and `rsp_pa_o` is 0.
- R5: A write request faults with `rsp_cause_o` = 2 and `rsp_level_o` = 0 when bit 1 (writable) is 0 in any of the four entries. A read through the same entries succeeds.
- R6: A user-mode request faults with cause 2 and level 0 when bit 2 (user) is 0 in any of the four entries.
- R7: An instruction fetch faults with cause 2 and level 0 when bit 63 (execute-disable) is 1 in any of the four entries. A data read of that page succeeds, and so does a fetch from a page with bit 63 clear in every entry.
- R8: `req_ready_o` is 0 from acceptance until the response is taken. At most one memory read is outstanding. `mem_req_valid_o` and `mem_req_addr_o` hold steady until `mem_req_ready_i` is seen.
- R9: While `rsp_valid_o` is 1 and `rsp_ready_i` is 0, every response field holds steady. `rsp_va_o` returns the accepted virtual address.
- R10: VA 0x100001 becomes PA 0x8001 when the indices for the top three levels are 0 and last-level entry 256 holds page number 0x8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base_i | input | 48 | Physical base of the top-level table (bits 11:0 ignored) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept |
| req_va_i | input | 64 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 48 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_pa_o | output | 48 | Physical address (0 on fault) |
| rsp_cause_o | output | 2 | 0 success, 1 missing entry, 2 protection |
| rsp_level_o | output | 2 | Level where the walk stopped (3 top … 0 last) |
| rsp_va_o | output | 64 | Virtual address of this result |

## Verification
Suppose the captured level counter or the saved table base goes wrong. The very next `mem_req_addr_o` then points at the wrong entry, so the fault shows at the port within one read of the error. It later shows again as a wrong physical address or fault level. A corrupted permission accumulator stays hidden until the last entry returns. Only the cause code shows it, one cycle after that read. A state machine that skips or repeats a level changes the read count and the reported level. A lost response-hold state shows as fields that change, or a dropped valid, while the requester stalls.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 64;
    localparam int PA_W      = 48;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 9;
    localparam int LEVELS    = 4;
    localparam int ENT_W     = 64;
    localparam int ENT_SHIFT = 3;
    localparam int LVL_W     = $clog2(LEVELS);
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int VA_USED   = OFF_W + LEVELS * IDX_W;
    localparam int CAUSE_W   = 2;

    localparam int BIT_PRESENT = 0;
    localparam int BIT_WRITE   = 1;
    localparam int BIT_USER    = 2;
    localparam int BIT_NOEXEC  = 63;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_ABSENT = 2'd1,
        CAUSE_PROT   = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic wr;
        logic usr;
        logic fetch;
    } access_t;

    typedef struct packed {
        logic wr_ok;
        logic usr_ok;
        logic exec_ok;
    } perm_t;
endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int LEVELS    = 4,
    parameter int IDX_W     = 9,
    parameter int OFF_W     = 12,
    parameter int PA_W      = 48,
    parameter int ENT_SHIFT = 3,
    localparam int LVL_W    = $clog2(LEVELS),
    localparam int VA_USED  = OFF_W + LEVELS * IDX_W,
    localparam int PPN_W    = PA_W - OFF_W
) (
    input  logic [VA_USED-1:0] va_i,
    input  logic [LVL_W-1:0]   level_i,
    input  logic [PPN_W-1:0]   base_ppn_i,
    output logic [PA_W-1:0]    entry_addr_o
);
    logic [IDX_W-1:0] idx_arr [LEVELS];
    logic [PA_W-1:0]  byte_ofs;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_arr[g] = va_i[OFF_W + g*IDX_W +: IDX_W];
    end

    logic unused_offset;
    assign unused_offset = ^va_i[OFF_W-1:0];

    always_comb begin
        byte_ofs = '0;
        byte_ofs[IDX_W+ENT_SHIFT-1:0] = {idx_arr[level_i], {ENT_SHIFT{1'b0}}};
        entry_addr_o = {base_ppn_i, {OFF_W{1'b0}}} + byte_ofs;
    end
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  perm_t   perm_i,
    input  access_t acc_i,
    input  logic    wr_bit_i,
    input  logic    usr_bit_i,
    input  logic    nx_bit_i,
    output perm_t   perm_o,
    output logic    violation_o
);
    always_comb begin
        perm_o.wr_ok   = perm_i.wr_ok   &  wr_bit_i;
        perm_o.usr_ok  = perm_i.usr_ok  &  usr_bit_i;
        perm_o.exec_ok = perm_i.exec_ok & ~nx_bit_i;
        violation_o = (acc_i.wr    & ~perm_o.wr_ok)
                    | (acc_i.usr   & ~perm_o.usr_ok)
                    | (acc_i.fetch & ~perm_o.exec_ok);
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [47:0]     root_base_i,
    input  logic            req_valid_i,
    output logic            req_ready_o,
    input  logic [63:0]     req_va_i,
    input  logic            req_write_i,
    input  logic            req_user_i,
    input  logic            req_fetch_i,
    output logic            mem_req_valid_o,
    input  logic            mem_req_ready_i,
    output logic [47:0]     mem_req_addr_o,
    input  logic            mem_rsp_valid_i,
    input  logic [63:0]     mem_rsp_data_i,
    output logic            rsp_valid_o,
    input  logic            rsp_ready_i,
    output logic [47:0]     rsp_pa_o,
    output logic [1:0]      rsp_cause_o,
    output logic [1:0]      rsp_level_o,
    output logic [63:0]     rsp_va_o
);
    typedef struct packed {
        state_e             state;
        logic [VA_W-1:0]    va;
        access_t            acc;
        logic [PPN_W-1:0]   ppn;
        logic [LVL_W-1:0]   level;
        perm_t              perm;
        cause_e             cause;
        logic [LVL_W-1:0]   stop_level;
        logic [PA_W-1:0]    pa;
    } walk_t;

    walk_t q, d;

    logic  [PA_W-1:0] entry_addr;
    perm_t            perm_next;
    logic             perm_violation;

    ptw_index_sel #(
        .LEVELS   (LEVELS),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .PA_W     (PA_W),
        .ENT_SHIFT(ENT_SHIFT)
    ) u_index_sel (
        .va_i        (q.va[VA_USED-1:0]),
        .level_i     (q.level),
        .base_ppn_i  (q.ppn),
        .entry_addr_o(entry_addr)
    );

    ptw_perm_check u_perm_check (
        .perm_i     (q.perm),
        .acc_i      (q.acc),
        .wr_bit_i   (mem_rsp_data_i[BIT_WRITE]),
        .usr_bit_i  (mem_rsp_data_i[BIT_USER]),
        .nx_bit_i   (mem_rsp_data_i[BIT_NOEXEC]),
        .perm_o     (perm_next),
        .violation_o(perm_violation)
    );

    logic unused_bits;
    assign unused_bits = ^{root_base_i[OFF_W-1:0],
                           mem_rsp_data_i[ENT_W-2:PA_W],
                           mem_rsp_data_i[OFF_W-1:BIT_USER+1]};

    always_comb begin
        d = q;
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.state      = ST_ISSUE;
                    d.va         = req_va_i;
                    d.acc        = '{wr: req_write_i, usr: req_user_i, fetch: req_fetch_i};
                    d.ppn        = root_base_i[PA_W-1:OFF_W];
                    d.level      = LVL_W'(LEVELS - 1);
                    d.perm       = '1;
                    d.cause      = CAUSE_NONE;
                    d.stop_level = '0;
                    d.pa         = '0;
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready_i) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!mem_rsp_data_i[BIT_PRESENT]) begin
                        d.state      = ST_DONE;
                        d.cause      = CAUSE_ABSENT;
                        d.stop_level = q.level;
                    end else begin
                        d.perm = perm_next;
                        if (q.level == '0) begin
                            d.state = ST_DONE;
                            if (perm_violation) begin
                                d.cause = CAUSE_PROT;
                            end else begin
                                d.pa = {mem_rsp_data_i[PA_W-1:OFF_W], q.va[OFF_W-1:0]};
                            end
                        end else begin
                            d.state = ST_ISSUE;
                            d.ppn   = mem_rsp_data_i[PA_W-1:OFF_W];
                            d.level = q.level - LVL_W'(1);
                        end
                    end
                end
            end
            ST_DONE: begin
                if (rsp_ready_i) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready_o     = (q.state == ST_IDLE);
    assign mem_req_valid_o = (q.state == ST_ISSUE);
    assign mem_req_addr_o  = entry_addr;
    assign rsp_valid_o     = (q.state == ST_DONE);
    assign rsp_pa_o        = q.pa;
    assign rsp_cause_o     = q.cause;
    assign rsp_level_o     = q.stop_level;
    assign rsp_va_o        = q.va;
endmodule

// File: rtl/ptw_walker_checker.sv
module ptw_walker_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic        mem_req_valid_o,
    input logic        mem_req_ready_i,
    input logic [47:0] mem_req_addr_o,
    input logic        mem_rsp_valid_i,
    input logic        rsp_valid_o,
    input logic        rsp_ready_i,
    input logic [47:0] rsp_pa_o,
    input logic [1:0]  rsp_cause_o,
    input logic [1:0]  rsp_level_o,
    input logic [63:0] rsp_va_o
);
    logic       outstanding;
    logic [2:0] reads;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding <= 1'b0;
            reads       <= '0;
        end else begin
            if (mem_req_valid_o && mem_req_ready_i) outstanding <= 1'b1;
            else if (mem_rsp_valid_i)               outstanding <= 1'b0;
            if (req_valid_i && req_ready_o)         reads <= '0;
            else if (mem_req_valid_o && mem_req_ready_i) reads <= reads + 3'd1;
        end
    end

    a_r8_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> !outstanding);

    a_r8_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o || rsp_valid_o) |-> !req_ready_o);

    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_pa_o)
            && $stable(rsp_cause_o) && $stable(rsp_level_o) && $stable(rsp_va_o));

    a_r3_four_reads: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_cause_o == 2'd0 |-> reads == 3'd4);

    a_r3_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_cause_o == 2'd0 |-> rsp_pa_o[11:0] == rsp_va_o[11:0]);

    a_r4_read_limit: assert property (@(posedge clk) disable iff (!rst_n)
        reads <= 3'd4);

    a_r4_no_read_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !mem_req_valid_o && !outstanding);

    a_r5_prot_level: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o && rsp_cause_o == 2'd2 |-> rsp_level_o == 2'd0 && rsp_pa_o == '0);
endmodule

bind ptw_walker ptw_walker_checker u_ptw_walker_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .mem_req_valid_o(mem_req_valid_o),
    .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o (mem_req_addr_o),
    .mem_rsp_valid_i(mem_rsp_valid_i),
    .rsp_valid_o    (rsp_valid_o),
    .rsp_ready_i    (rsp_ready_i),
    .rsp_pa_o       (rsp_pa_o),
    .rsp_cause_o    (rsp_cause_o),
    .rsp_level_o    (rsp_level_o),
    .rsp_va_o       (rsp_va_o)
);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 14;
    localparam int  WAIT_LIMIT = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] root_base = 48'h10000;
    logic        req_valid = 1'b0, req_ready;
    logic [63:0] req_va = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
    logic        mem_req_valid, mem_req_ready = 1'b0;
    logic [47:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid, rsp_ready = 1'b1;
    logic [47:0] rsp_pa;
    logic [1:0]  rsp_cause, rsp_level;
    logic [63:0] rsp_va;

    int tests = 0, failed = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker dut (
        .clk(clk), .rst_n(rst_n), .root_base_i(root_base),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
        .req_write_i(req_write), .req_user_i(req_user), .req_fetch_i(req_fetch),
        .mem_req_valid_o(mem_req_valid), .mem_req_ready_i(mem_req_ready),
        .mem_req_addr_o(mem_req_addr), .mem_rsp_valid_i(mem_rsp_valid),
        .mem_rsp_data_i(mem_rsp_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
        .rsp_pa_o(rsp_pa), .rsp_cause_o(rsp_cause), .rsp_level_o(rsp_level), .rsp_va_o(rsp_va)
    );

    // sparse entry memory and model
    logic [63:0] pmem [logic [47:0]];
    logic        pend = 1'b0;
    int          pend_cnt = 0;
    logic [47:0] pend_addr = '0;
    int          ncyc = 0;
    int          nreads = 0;
    logic [47:0] first_addr = '0, last_addr = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 1'b0; mem_rsp_valid = 1'b0; mem_req_ready = 1'b0;
        end else begin
            mem_rsp_valid = 1'b0;
            if (pend) begin
                if (pend_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = pmem.exists(pend_addr) ? pmem[pend_addr] : 64'h0;
                    pend = 1'b0;
                end else pend_cnt--;
            end
            mem_req_ready = (ncyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                pend = 1'b1; pend_addr = mem_req_addr; pend_cnt = ncyc % 2;
                nreads++;
                if (nreads == 1) first_addr = mem_req_addr;
                last_addr = mem_req_addr;
            end
            ncyc++;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [63:0] va;
        logic        w, u, f;
        logic [1:0]  cause;
        logic [1:0]  lvl;
        logic [47:0] pa;
        logic [2:0]  nrd;
        logic [47:0] last;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{64'h100001,            1'b0,1'b0,1'b0, 2'd0,2'd0, 48'h8001,         3'd4, 48'h13800},
        '{64'h100001,            1'b1,1'b1,1'b0, 2'd0,2'd0, 48'h8001,         3'd4, 48'h13800},
        '{64'h101abc,            1'b0,1'b0,1'b0, 2'd0,2'd0, 48'h9abc,         3'd4, 48'h13808},
        '{64'h101abc,            1'b1,1'b0,1'b0, 2'd2,2'd0, 48'h0,            3'd4, 48'h13808},
        '{64'h101abc,            1'b0,1'b1,1'b0, 2'd2,2'd0, 48'h0,            3'd4, 48'h13808},
        '{64'h102123,            1'b0,1'b0,1'b1, 2'd2,2'd0, 48'h0,            3'd4, 48'h13810},
        '{64'h102123,            1'b0,1'b1,1'b0, 2'd0,2'd0, 48'hA123,         3'd4, 48'h13810},
        '{64'h103000,            1'b0,1'b0,1'b0, 2'd1,2'd0, 48'h0,            3'd4, 48'h13818},
        '{64'h200000,            1'b0,1'b0,1'b0, 2'd1,2'd1, 48'h0,            3'd3, 48'h12008},
        '{64'h40000000,          1'b0,1'b0,1'b0, 2'd1,2'd2, 48'h0,            3'd2, 48'h11008},
        '{64'h8000000000,        1'b0,1'b0,1'b0, 2'd1,2'd3, 48'h0,            3'd1, 48'h10008},
        '{64'h281C13FFFED,       1'b1,1'b0,1'b0, 2'd0,2'd0, 48'h123456789FED, 3'd4, 48'h23FF8},
        '{64'h281C13FFFED,       1'b0,1'b1,1'b0, 2'd2,2'd0, 48'h0,            3'd4, 48'h23FF8},
        '{64'hABCD0281C13FFFED,  1'b0,1'b0,1'b1, 2'd0,2'd0, 48'h123456789FED, 3'd4, 48'h23FF8}
    };

    // issue one request; hold > 0 keeps rsp_ready low that many cycles
    task automatic run_req(input logic [63:0] va, input logic w, input logic u, input logic f,
                           input int hold, output logic [47:0] pa, output logic [1:0] cause,
                           output logic [1:0] lvl);
        int guard = 0;
        @(negedge clk);
        nreads = 0;
        rsp_ready = (hold == 0);
        req_va = va; req_write = w; req_user = u; req_fetch = f; req_valid = 1'b1;
        while (!req_ready && guard < WAIT_LIMIT) begin @(negedge clk); guard++; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 ready low while walking", {63'b0, req_ready}, 64'd0);
        guard = 0;
        while (!rsp_valid && guard < WAIT_LIMIT) begin @(negedge clk); guard++; end
        if (guard >= WAIT_LIMIT) check("R8 response timeout", 64'd1, 64'd0);
        pa = rsp_pa; cause = rsp_cause; lvl = rsp_level;
        check("R9 va echoed", rsp_va, va);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R9 valid held", {63'b0, rsp_valid}, 64'd1);
            check("R9 pa held", {16'b0, rsp_pa}, {16'b0, pa});
            check("R9 cause held", {62'b0, rsp_cause}, {62'b0, cause});
            check("R8 ready low while response pending", {63'b0, req_ready}, 64'd0);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R9 response released", {63'b0, rsp_valid}, 64'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failed++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        logic [47:0] pa;
        logic [1:0]  cause, lvl;
        string       tag;
        // tree: root 0x10000 -> 0x11000 -> 0x12000 -> 0x13000
        pmem[48'h10000] = 64'h11007;
        pmem[48'h11000] = 64'h7FFF_0000_0001_2007;  // junk in 62:48 ignored (R3)
        pmem[48'h12000] = 64'h13007;
        pmem[48'h13800] = 64'h8007;                  // entry 256
        pmem[48'h13808] = 64'h9001;                  // read-only, kernel
        pmem[48'h13810] = 64'h8000_0000_0000_A007;   // execute-disable
        // second branch: L4[5] lacks user bit
        pmem[48'h10028] = 64'h21003;
        pmem[48'h21038] = 64'h22007;
        pmem[48'h22048] = 64'h23007;
        pmem[48'h23FF8] = 64'h1234_5678_9007;

        repeat (3) @(negedge clk);
        check("R1 req_ready in reset", {63'b0, req_ready}, 64'd1);
        check("R1 rsp_valid in reset", {63'b0, rsp_valid}, 64'd0);
        check("R1 mem_req_valid in reset", {63'b0, mem_req_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 req_ready after reset", {63'b0, req_ready}, 64'd1);

        for (int i = 0; i < N_VEC; i++) begin
            run_req(VECS[i].va, VECS[i].w, VECS[i].u, VECS[i].f, 0, pa, cause, lvl);
            if (i == 0)                     tag = "R10";
            else if (VECS[i].cause == 2'd1) tag = "R4";
            else if (VECS[i].cause == 2'd0) tag = (VECS[i].f || i == 3) ? "R7" : "R3";
            else if (VECS[i].w)             tag = "R5";
            else if (VECS[i].u)             tag = "R6";
            else                            tag = "R7";
            check({tag, " cause"}, {62'b0, cause}, {62'b0, VECS[i].cause});
            check({tag, " level"}, {62'b0, lvl}, {62'b0, VECS[i].lvl});
            check({tag, " pa"}, {16'b0, pa}, {16'b0, VECS[i].pa});
            check({tag, " read count"}, 64'(nreads), 64'(VECS[i].nrd));
            check("R2 last entry address", {16'b0, last_addr}, {16'b0, VECS[i].last});
            check("R2 first entry address", {16'b0, first_addr},
                  {16'b0, 48'h10000 + {36'b0, VECS[i].va[47:39], 3'b000}});
        end

        // R2: root low bits ignored
        root_base = 48'h10ABC;
        run_req(64'h100001, 1'b0, 1'b0, 1'b0, 0, pa, cause, lvl);
        check("R2 root low bits masked", {16'b0, first_addr}, 64'h10000);
        check("R10 pa with unaligned root", {16'b0, pa}, 64'h8001);
        root_base = 48'h10000;

        // R9: responder stalls
        run_req(64'h101abc, 1'b1, 1'b0, 1'b0, 4, pa, cause, lvl);
        check("R5 cause under stall", {62'b0, cause}, 64'd2);

        // R4: entry changed to absent between requests
        pmem[48'h13800] = 64'h8006;
        run_req(64'h100001, 1'b0, 1'b0, 1'b0, 0, pa, cause, lvl);
        check("R4 cleared present bit", {62'b0, cause}, 64'd1);
        check("R4 no pa on fault", {16'b0, pa}, 64'd0);

        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule